// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Cell

This block is one output cell of a small programmable AND-OR array. It takes a vector of array inputs. Eight product terms are formed from those inputs, each set by a pair of connection masks: one selects true literals, the other selects complemented literals. Four terms are ORed into the data function. The other four act as the register clock, the asynchronous set, the asynchronous reset and the output enable. There is no global clock. The single D register is clocked by the rising edge of its own clock term.

When neither the set term nor the reset term has any literal connected, both are constant HIGH. The cell then bypasses the register and drives the data sum straight through. A configuration bit can invert the output. The output enable term is ANDed with a shared active-low enable input. A feedback output returns the driven value to the array, or the value on the pin when the cell is not driving it.

For test, an active-low preload input forces the register to the value presented on the pin. An active-low power-on clear overrides everything else.

Top module: `pal_macrocell`

## Requirements
- R1: Product term k (0..7) connects true input i when `lit_true[k*N_IN+i]` is 1, and connects the complement of input i when `lit_comp[k*N_IN+i]` is 1. The term is the AND of its connected literals. A term with no literal connected is HIGH. A term with both literals of any input connected is always LOW.
- R2: The data function is the OR of terms 0 to 3.
- R3: When the masks of terms 5 and 6 are all zero, the cell is combinational. The output follows the data function with no clock edge.
- R4: `pin_oe` is 1 exactly when term 7 is HIGH and `oe_ext_n` is 0.
- R5: `pin_o` equals the combinational or registered value when `inv_out` is 0, and its complement when `inv_out` is 1.
- R6: In registered mode, the register takes the data function on each rising edge of term 4 and holds its value at all other times.
- R7: Term 5 sets the register and term 6 clears it, both asynchronously. When both are HIGH, set wins. When set falls while reset is still HIGH, the register clears.
- R8: While `pl_n` is 0, the register asynchronously follows `pin_i`, and edges of term 4 are ignored. The loaded value remains after `pl_n` returns to 1.
- R9: While `por_n` is 0, the register is 0, even if preload is active. With `inv_out` set, the output therefore reads 1.
- R10: `fb` equals `pin_o` when `pin_oe` is 1, and equals `pin_i` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arr_in | input | N_IN | Array input vector |
| lit_true | input | 8*N_IN | True-literal connection mask, term k at bits k*N_IN upward |
| lit_comp | input | 8*N_IN | Complement-literal connection mask, same layout |
| inv_out | input | 1 | 1 inverts the output |
| oe_ext_n | input | 1 | Shared active-low output enable |
| pl_n | input | 1 | Active-low register preload |
| por_n | input | 1 | Active-low power-on clear |
| pin_i | input | 1 | Value present on the pad |
| pin_o | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad drive enable |
| fb | output | 1 | Feedback to the array |

## Verification
The register is hidden behind the polarity stage. A wrong register state therefore shows up as an inverted or stuck `pin_o`, and through `fb` while the cell drives the pad. Because set, reset, preload and clear all act without a clock, a fault in their priority shows at the output as soon as the responsible input changes. A wrong capture shows just after the rising edge of the clock term. Both are checked at those points.

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int N_IN = 6
) (
  input  logic [N_IN-1:0]   arr_in,
  input  logic [8*N_IN-1:0] lit_true,
  input  logic [8*N_IN-1:0] lit_comp,
  input  logic              inv_out,
  input  logic              oe_ext_n,
  input  logic              pl_n,
  input  logic              por_n,
  input  logic              pin_i,
  output logic              pin_o,
  output logic              pin_oe,
  output logic              fb
);
  localparam int N_PT = 8;
  localparam int T_CK = 4;
  localparam int T_SET = 5;
  localparam int T_RST = 6;
  localparam int T_OE = 7;

  logic [N_PT-1:0] pt;

  for (genvar k = 0; k < N_PT; k++) begin : g_term
    assign pt[k] = (&(~lit_true[k*N_IN +: N_IN] | arr_in)) &
                   (&(~lit_comp[k*N_IN +: N_IN] | ~arr_in));
  end

  logic data_sum, comb_mode, ck_pt, aset, aclr, q, core;

  assign data_sum  = |pt[3:0];
  assign comb_mode = ~|{lit_true[T_SET*N_IN +: N_IN], lit_comp[T_SET*N_IN +: N_IN],
                        lit_true[T_RST*N_IN +: N_IN], lit_comp[T_RST*N_IN +: N_IN]};
  assign ck_pt     = pt[T_CK];

  assign aset = por_n & (pl_n ? pt[T_SET] : pin_i);
  assign aclr = ~por_n | (pl_n ? (~pt[T_SET] & pt[T_RST]) : ~pin_i);

  always_ff @(posedge ck_pt or posedge aset or posedge aclr) begin
    if (aclr)      q <= 1'b0;
    else if (aset) q <= 1'b1;
    else           q <= data_sum;
  end

  assign core   = comb_mode ? data_sum : q;
  assign pin_o  = core ^ inv_out;
  assign pin_oe = pt[T_OE] & ~oe_ext_n;
  assign fb     = pin_oe ? pin_o : pin_i;

  a_r8_preload_tracks_pin: assert property (@(posedge ck_pt) disable iff (!por_n)
    !pl_n |-> (q == pin_i));
  a_r7_set_holds_high: assert property (@(posedge ck_pt) disable iff (!por_n)
    (pl_n && pt[T_SET]) |-> q);
  a_r7_reset_holds_low: assert property (@(posedge ck_pt) disable iff (!por_n)
    (pl_n && !pt[T_SET] && pt[T_RST]) |-> !q);
  a_r4_ext_enable_gates: assert property (@(posedge ck_pt) disable iff (!por_n)
    pin_oe |-> !oe_ext_n);
  a_r10_fb_from_pad: assert property (@(posedge ck_pt) disable iff (!por_n)
    !pin_oe |-> (fb == pin_i));
endmodule

// File: tb/tb_pal_macrocell.sv
module tb_pal_macrocell;
  localparam int N = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]   ain;
  logic [8*N-1:0] lt, lc;
  logic inv, oen, pln, porn, pini;
  logic po, poe, fbk;

  pal_macrocell #(.N_IN(N)) dut (
    .arr_in(ain), .lit_true(lt), .lit_comp(lc), .inv_out(inv),
    .oe_ext_n(oen), .pl_n(pln), .por_n(porn), .pin_i(pini),
    .pin_o(po), .pin_oe(poe), .fb(fbk)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {inputs[5:0], expected} for (i1&i2) | ~i3 | (i4&~i5)
  localparam logic [6:0] VEC [8] = '{
    {6'b000000, 1'b1}, {6'b001000, 1'b0}, {6'b001110, 1'b1}, {6'b011000, 1'b1},
    {6'b111000, 1'b0}, {6'b001010, 1'b0}, {6'b101100, 1'b0}, {6'b111110, 1'b1}
  };

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic term(input int k, input logic [N-1:0] t, input logic [N-1:0] c);
    lt[k*N +: N] = t;
    lc[k*N +: N] = c;
  endtask

  task automatic cfg_registered();
    term(0, 6'b000010, 6'b000000);
    for (int k = 1; k < 4; k++) term(k, 6'b000010, 6'b000010);
    term(4, 6'b000001, 6'b000000);
    term(5, 6'b100000, 6'b000000);
    term(6, 6'b010000, 6'b000000);
    term(7, 6'b000100, 6'b000000);
    inv = 1'b1;
  endtask

  task automatic cfg_comb();
    term(0, 6'b000110, 6'b000000);
    term(1, 6'b000000, 6'b001000);
    term(2, 6'b000010, 6'b000010);
    term(3, 6'b010000, 6'b100000);
    for (int k = 4; k < 8; k++) term(k, 6'b000000, 6'b000000);
    inv = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    lt = '0; lc = '0;
    porn = 1'b0; pln = 1'b1; oen = 1'b0; pini = 1'b0;
    ain = 6'b000100;
    cfg_registered();
    settle();
    chk("R9 clear reads high", po, 1'b1);
    chk("R4 enabled", poe, 1'b1);
    chk("R10 fb driven", fbk, 1'b1);
    porn = 1'b1; settle();
    chk("R9 after release", po, 1'b1);

    ain = 6'b000110; settle();
    chk("R6 hold without edge", po, 1'b1);
    ain = 6'b000111; settle();
    chk("R6 capture 1", po, 1'b0);
    ain = 6'b000101; settle();
    chk("R6 hold high clock", po, 1'b0);
    ain = 6'b000100; settle();
    chk("R6 hold falling edge", po, 1'b0);
    ain = 6'b000101; settle();
    chk("R6 capture 0", po, 1'b1);
    ain = 6'b000100; settle();

    ain = 6'b100100; settle();
    chk("R7 async set", po, 1'b0);
    ain = 6'b110100; settle();
    chk("R7 set wins", po, 1'b0);
    ain = 6'b010100; settle();
    chk("R7 reset after set falls", po, 1'b1);
    ain = 6'b000100; settle();

    oen = 1'b1; settle();
    chk("R4 external disable", poe, 1'b0);
    pini = 1'b1; settle();
    chk("R10 fb from pad", fbk, 1'b1);
    pln = 1'b0; settle();
    chk("R8 preload 1", po, 1'b0);
    ain = 6'b000101; settle();
    chk("R8 clock ignored", po, 1'b0);
    ain = 6'b000100; settle();
    pln = 1'b1; settle();
    chk("R8 kept after release", po, 1'b0);
    pini = 1'b0; settle();
    pln = 1'b0; settle();
    chk("R8 preload 0", po, 1'b1);
    pln = 1'b1; settle();

    pini = 1'b1; pln = 1'b0; settle();
    chk("R8 preload again", po, 1'b0);
    porn = 1'b0; settle();
    chk("R9 overrides preload", po, 1'b1);
    pln = 1'b1; settle();
    porn = 1'b1; settle();
    chk("R9 stays clear", po, 1'b1);

    oen = 1'b0; settle();
    chk("R4 both enable", poe, 1'b1);
    ain = 6'b000000; pini = 1'b0; settle();
    chk("R4 term low", poe, 1'b0);
    chk("R10 fb pad when term off", fbk, 1'b0);

    cfg_comb();
    for (int v = 0; v < 8; v++) begin
      ain = VEC[v][6:1];
      settle();
      chk("R2 R3 comb sum", po, VEC[v][0]);
      chk("R10 fb follows output", fbk, VEC[v][0]);
    end

    inv = 1'b1; ain = 6'b000000; settle();
    chk("R5 inverted", po, 1'b0);
    ain = 6'b001000; settle();
    chk("R5 inverted low", po, 1'b1);

    inv = 1'b0;
    for (int k = 0; k < 4; k++) term(k, 6'b111111, 6'b111111);
    ain = 6'b111111; settle();
    chk("R1 full mask low", po, 1'b0);
    ain = 6'b000000; settle();
    chk("R1 full mask low zeros", po, 1'b0);
    term(0, 6'b000000, 6'b000000); settle();
    chk("R1 empty term high", po, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule